// File: doc/BRIEF.md
# Gate-Driver Vertical Scan Sequencer

The sequencer produces the field timing for the row drivers of an active-matrix panel. A line strobe from the horizontal timing marks the start of each line period. The block counts these strobes into fields and drives the vertical start pulse into the gate-driver chain. The pulse goes out on one of two bidirectional start pins, picked by a scan-direction select. The undriven pin is released so the far end of the chain can use it.

A single cycle counter restarts on every strobe. From that count the block derives one gate shift clock pulse and three staggered gate output-enable pulses in each line. Lines inside the visible window carry short enable pulses. Lines outside it carry long enable pulses, which are cut off by the next strobe. When interlace is enabled, fields alternate odd and even, and each kind of field starts its vertical pulse at its own offset. All delays are parameters counted in master clocks; the defaults assume a 28.8 MHz clock.

Top module: `vscan_seq`

## Requirements
- R1: After reset, and until the first line strobe, `gclk_o`, `gate_en_o`, `vstart_fwd_o`, `vstart_rev_o` and `field_o` are all 0.
- R2: In every line, `gclk_o` is high for exactly `CKV_W_CYC` clocks. It is high in line cycles 0 to `CKV_W_CYC`-1, where line cycle 0 is the clock period that follows the edge sampling `line_i` high.
- R3: Gate enable `gate_en_o[k]` (k = 0, 1, 2) goes high in line cycle `OE1_OFS_CYC + k*OE_GAP_CYC`.
- R4: On a visible line, each enable stays high for `OE_SHORT_CYC` clocks. On any other line it stays high for `OE_LONG_CYC` clocks, or until the next line strobe if that comes first.
- R5: The first strobe after reset begins line 0 of an odd field. Line indices then step by one per strobe and wrap to 0 after `FIELD_LINES`-1. Lines `VIS_START` to `VIS_START+VIS_LINES-1` are the visible ones.
- R6: In an odd field, the vertical start pulse goes high in line 0 at line cycle `STV_ODD_CYC` and stays high for `STV_W_CYC` consecutive clocks.
- R7: In an even field, the vertical start pulse goes high in line 0 at line cycle `STV_EVEN_CYC`, with the same width.
- R8: With `scan_fwd_i` = 1, `vstart_fwd_oe_o` = 1 and `vstart_fwd_o` carries the pulse, while `vstart_rev_oe_o` and `vstart_rev_o` are 0. With `scan_fwd_i` = 0, the roles swap. Both paths follow the select within the same clock period.
- R9: At each field wrap, with interlace enabled, `field_o` toggles (0 = odd, 1 = even). With interlace disabled, it becomes 0, so the odd offset is used for every field.
- R10: `field_o` changes only on the strobe edge that begins line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Line strobe, one clock wide |
| scan_fwd_i | input | 1 | 1: top-to-bottom scan, 0: bottom-to-top |
| ilace_en_i | input | 1 | Enable odd/even field alternation |
| vstart_fwd_o | output | 1 | Vertical start data for the top-end pin |
| vstart_fwd_oe_o | output | 1 | Drive enable for the top-end pin |
| vstart_rev_o | output | 1 | Vertical start data for the bottom-end pin |
| vstart_rev_oe_o | output | 1 | Drive enable for the bottom-end pin |
| gclk_o | output | 1 | Gate shift clock |
| gate_en_o | output | 3 | Staggered gate output enables |
| field_o | output | 1 | Field flag, 1 = even |

## Verification
A corrupted cycle counter misplaces the shift clock or one of the enables within the same line, at the exact cycle where the bench compares every output. A wrong line index shows up on the first line whose enable width is wrong: a visible line with long pulses, or a blanking line with short ones. It also moves the start pulse into the wrong line, and that is seen within one field at most. A wrong field flag shows on the flag itself from the next clock, and as a shifted start pulse at the following line 0. The bench steps through every cycle of several whole fields under both interlace settings, both scan directions, two line lengths, and a direction change in the middle of each line.

// File: rtl/vscan_pkg.sv
package vscan_pkg;
  localparam int unsigned NUM_OE = 3;

  typedef enum logic {FLD_ODD = 1'b0, FLD_EVEN = 1'b1} field_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/vscan_line_timer.sv
module vscan_line_timer
  import vscan_pkg::*;
#(
  parameter int unsigned CKV_W_CYC    = 455,
  parameter int unsigned OE1_OFS_CYC  = 429,
  parameter int unsigned OE_GAP_CYC   = 521,
  parameter int unsigned OE_SHORT_CYC = 121,
  parameter int unsigned OE_LONG_CYC  = 2350,
  parameter int unsigned CNT_W        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              vis_i,
  output logic              run_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              gclk_o,
  output logic [NUM_OE-1:0] gate_en_o
);
  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      cnt_w;
  logic [31:0]      width_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (line_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_q != '1) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_w   = 32'(cnt_q);
  assign width_w = vis_i ? OE_SHORT_CYC : OE_LONG_CYC;
  assign gclk_o  = run_q && (cnt_w < CKV_W_CYC);
  assign run_o   = run_q;
  assign cnt_o   = cnt_q;

  for (genvar k = 0; k < NUM_OE; k++) begin : g_oe
    localparam int unsigned RISE = OE1_OFS_CYC + int'(k) * OE_GAP_CYC;
    assign gate_en_o[k] = run_q && (cnt_w >= RISE) && (cnt_w < RISE + width_w);
  end

  AST_CKV_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gclk_o) |-> $past(line_i)); // R2
endmodule

// File: rtl/vscan_field_ctrl.sv
module vscan_field_ctrl
  import vscan_pkg::*;
#(
  parameter int unsigned FIELD_LINES = 262,
  parameter int unsigned VIS_START   = 3,
  parameter int unsigned VIS_LINES   = 234
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   line_i,
  input  logic   run_i,
  input  logic   ilace_i,
  output logic   line0_o,
  output logic   vis_o,
  output field_e field_o
);
  localparam int unsigned LN_W = $clog2(FIELD_LINES);
  localparam logic [LN_W-1:0] LAST = LN_W'(FIELD_LINES - 1);

  logic [LN_W-1:0] line_q;
  field_e          field_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      field_q <= FLD_ODD;
    end else if (line_i) begin
      if (!run_i) begin
        line_q <= '0;
      end else if (line_q == LAST) begin
        line_q  <= '0;
        field_q <= !ilace_i ? FLD_ODD : ((field_q == FLD_ODD) ? FLD_EVEN : FLD_ODD);
      end else begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  assign line0_o = (line_q == '0);
  assign vis_o   = (32'(line_q) >= VIS_START) && (32'(line_q) < VIS_START + VIS_LINES);
  assign field_o = field_q;

  AST_LINE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(line_q) < FIELD_LINES); // R5
  AST_FIELD_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(field_q) |-> (line_q == '0) && $past(line_i)); // R10
  AST_FIELD_ODD_NOILACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!ilace_i) && !$stable(field_q)) |-> field_q == FLD_ODD); // R9
endmodule

// File: rtl/vscan_start_gen.sv
module vscan_start_gen
  import vscan_pkg::*;
#(
  parameter int unsigned STV_ODD_CYC  = 976,
  parameter int unsigned STV_EVEN_CYC = 63,
  parameter int unsigned STV_W_CYC    = 2743,
  parameter int unsigned CNT_W        = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             line0_i,
  input  field_e           field_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             scan_fwd_i,
  output logic             vstart_fwd_o,
  output logic             vstart_fwd_oe_o,
  output logic             vstart_rev_o,
  output logic             vstart_rev_oe_o
);
  localparam int unsigned SW_W = $clog2(STV_W_CYC + 1);

  logic [SW_W-1:0] wid_q;
  logic [31:0]     cnt_w;
  logic [31:0]     ofs_w;
  logic            fire;
  logic            active;

  assign cnt_w  = 32'(cnt_i);
  assign ofs_w  = (field_i == FLD_EVEN) ? STV_EVEN_CYC : STV_ODD_CYC;
  // fire one clock early so the pulse starts in line cycle ofs
  assign fire   = run_i && line0_i && (cnt_w + 32'd1 == ofs_w);
  assign active = (wid_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     wid_q <= '0;
    else if (fire)   wid_q <= SW_W'(STV_W_CYC);
    else if (active) wid_q <= wid_q - 1'b1;
  end

  assign vstart_fwd_oe_o = scan_fwd_i;
  assign vstart_rev_oe_o = !scan_fwd_i;
  assign vstart_fwd_o    = scan_fwd_i && active;
  assign vstart_rev_o    = !scan_fwd_i && active;

  AST_STV_LINE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> line0_i); // R6
  AST_STV_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active) |-> cnt_w == ofs_w); // R7
endmodule

// File: rtl/vscan_seq.sv
module vscan_seq
  import vscan_pkg::*;
#(
  parameter int unsigned FIELD_LINES  = 262,
  parameter int unsigned VIS_START    = 3,
  parameter int unsigned VIS_LINES    = 234,
  parameter int unsigned CKV_W_CYC    = 455,
  parameter int unsigned OE1_OFS_CYC  = 429,
  parameter int unsigned OE_GAP_CYC   = 521,
  parameter int unsigned OE_SHORT_CYC = 121,
  parameter int unsigned OE_LONG_CYC  = 2350,
  parameter int unsigned STV_ODD_CYC  = 976,
  parameter int unsigned STV_EVEN_CYC = 63,
  parameter int unsigned STV_W_CYC    = 2743
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_i,
  input  logic              scan_fwd_i,
  input  logic              ilace_en_i,
  output logic              vstart_fwd_o,
  output logic              vstart_fwd_oe_o,
  output logic              vstart_rev_o,
  output logic              vstart_rev_oe_o,
  output logic              gclk_o,
  output logic [NUM_OE-1:0] gate_en_o,
  output logic              field_o
);
  localparam int unsigned OE_END  = OE1_OFS_CYC + (NUM_OE - 1) * OE_GAP_CYC + OE_LONG_CYC;
  localparam int unsigned CNT_TOP = max_u(max_u(OE_END, CKV_W_CYC), max_u(STV_ODD_CYC, STV_EVEN_CYC));
  localparam int unsigned CNT_W   = $clog2(CNT_TOP + 1);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic             line0;
  logic             vis;
  field_e           field;

  vscan_line_timer #(
    .CKV_W_CYC(CKV_W_CYC), .OE1_OFS_CYC(OE1_OFS_CYC), .OE_GAP_CYC(OE_GAP_CYC),
    .OE_SHORT_CYC(OE_SHORT_CYC), .OE_LONG_CYC(OE_LONG_CYC), .CNT_W(CNT_W)
  ) u_line (
    .clk_i, .rst_ni, .line_i, .vis_i(vis), .run_o(run), .cnt_o(cnt),
    .gclk_o, .gate_en_o
  );

  vscan_field_ctrl #(
    .FIELD_LINES(FIELD_LINES), .VIS_START(VIS_START), .VIS_LINES(VIS_LINES)
  ) u_field (
    .clk_i, .rst_ni, .line_i, .run_i(run), .ilace_i(ilace_en_i),
    .line0_o(line0), .vis_o(vis), .field_o(field)
  );

  vscan_start_gen #(
    .STV_ODD_CYC(STV_ODD_CYC), .STV_EVEN_CYC(STV_EVEN_CYC),
    .STV_W_CYC(STV_W_CYC), .CNT_W(CNT_W)
  ) u_start (
    .clk_i, .rst_ni, .run_i(run), .line0_i(line0), .field_i(field), .cnt_i(cnt),
    .scan_fwd_i, .vstart_fwd_o, .vstart_fwd_oe_o, .vstart_rev_o, .vstart_rev_oe_o
  );

  assign field_o = (field == FLD_EVEN);
endmodule

// File: tb/sim_vscan_seq.sv
module sim_vscan_seq;
  localparam int FL = 262, VS = 3, VL = 234;
  localparam int CKW = 10, O1 = 8, OG = 9, OSH = 3, OLG = 50;
  localparam int SODD = 20, SEVN = 4, SW = 60;

  logic clk = 1'b0, rst_n = 1'b0, line = 1'b0, fwd = 1'b1, ilace = 1'b0;
  logic vf, vfoe, vr, vroe, gclk, fld;
  logic [2:0] gen;

  int n_chk = 0, n_err = 0;
  int m_line = 0, m_field = 0, abs_c = 0, stv_start = -1000000;
  bit started = 1'b0, done = 1'b0;

  always #4 clk = ~clk;

  vscan_seq #(
    .FIELD_LINES(FL), .VIS_START(VS), .VIS_LINES(VL), .CKV_W_CYC(CKW),
    .OE1_OFS_CYC(O1), .OE_GAP_CYC(OG), .OE_SHORT_CYC(OSH), .OE_LONG_CYC(OLG),
    .STV_ODD_CYC(SODD), .STV_EVEN_CYC(SEVN), .STV_W_CYC(SW)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .scan_fwd_i(fwd), .ilace_en_i(ilace),
    .vstart_fwd_o(vf), .vstart_fwd_oe_o(vfoe), .vstart_rev_o(vr), .vstart_rev_oe_o(vroe),
    .gclk_o(gclk), .gate_en_o(gen), .field_o(fld)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_cycle(input int k);
    int w, ofs;
    bit vis, s;
    logic [2:0] eo;
    #1;
    vis = (m_line >= VS) && (m_line < VS + VL);
    w   = vis ? OSH : OLG;
    for (int j = 0; j < 3; j++) eo[j] = (k >= O1 + j*OG) && (k < O1 + j*OG + w);
    ofs = m_field ? SEVN : SODD;
    if (m_line == 0 && k == ofs) stv_start = abs_c;
    s = (abs_c >= stv_start) && (abs_c < stv_start + SW);
    chk("R2", gclk, int'(k < CKW));
    chk(vis ? "R3" : "R4/R5", gen, eo);
    chk(m_field ? "R7" : "R6", vf | vr, s);
    chk("R8", {vf, vfoe, vr, vroe}, {fwd & s, fwd, ~fwd & s, ~fwd});
    chk("R9/R10", fld, m_field);
  endtask

  task automatic run_line(input int len, input bit flip);
    line = 1'b1;
    @(negedge clk);
    line = 1'b0;
    if (!started) begin
      started = 1'b1; m_line = 0;
    end else if (m_line == FL - 1) begin
      m_line = 0; m_field = ilace ? 1 - m_field : 0;
    end else begin
      m_line++;
    end
    for (int k = 0; k < len; k++) begin
      if (flip && k == 5) fwd = ~fwd;
      chk_cycle(k);
      abs_c++;
      if (k < len - 1) @(negedge clk);
    end
  endtask

  // R1 idle after reset, R8 direction select without strobes
  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", {gclk, gen, vf, vr, fld}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R1", {gclk, gen, vf, vr, fld}, 0);
    chk("R8", {vfoe, vroe}, 2'b10);
    fwd = 1'b0; #1;
    chk("R8", {vfoe, vroe}, 2'b01);
    fwd = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_fields(input int nf, input bit il, input bit dir, input int len, input bit flip);
    ilace = il; fwd = dir;
    for (int i = 0; i < nf * FL; i++) run_line(len, flip);
  endtask

  initial begin
    t_reset();
    t_fields(2, 1'b0, 1'b1, 40, 1'b0); // R9 odd offset held, R6
    t_fields(2, 1'b1, 1'b0, 40, 1'b0); // R7 even field, reverse scan
    t_fields(1, 1'b1, 1'b1, 35, 1'b1); // R4 clipping, R8 mid-line flips
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1600000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule